// File: doc/BRIEF.md
# Slave-Driven DRAM Refresh Sequencer

This block keeps dynamic main memory refreshed without a dedicated refresh controller. It borrows the address strobes of a small voice-sample processor, called the slave here, whose loop runs once every 125 us. Software in that loop raises a refresh flag when it enters a run of consecutive instructions and lowers it when it leaves that run. While the flag is up, each slave address strobe also launches a shadow reference to main memory. The slave's instruction words still come from its own ROM, and the data that comes back from main memory is discarded.

The low address bits of each shadow reference come from an internal row counter, which advances by one for every reference that is launched. The upper bits follow the slave's address. The memory needs 256 row activations in every 4 ms window, so each 125 us sample period must launch at least 8 references. A shadow reference is a valid/ready-style request: `mem_req` is valid and `mem_ack` is the grant. The request and its address stay fixed until the cycle in which the grant is seen. While a request is outstanding, the slave's ready line is held low, which inserts wait states into the slave's cycle.

A monitor counts the completed references in each sample period. At every sample tick it reports any period that completed fewer than the required number.

Top module: `rdr_refresh_seq`

## Requirements
- R1: The refresh flag is set by `refresh_on` and cleared by `refresh_off`. When both are high in the same cycle, the clear wins. A strobe launches a reference only if the flag was already set before that cycle's clock edge.
- R2: The row counter advances by one on each accepted strobe and wraps from 255 to 0. It holds its value while the flag is clear, and it also holds for strobes that are ignored. A reference carries the counter value from before the step in `mem_addr[7:0]`.
- R3: `mem_addr` bits above the row field equal the upper bits of `slave_addr` sampled with the accepted strobe. The whole address is valid from the cycle after the strobe.
- R4: `mem_req` rises in the cycle after an accepted strobe. It stays high, with `mem_addr` stable, through the first cycle in which `mem_ack` is high, and it is low in the cycle after that.
- R5: `slave_ready` is low exactly while a request is outstanding. Strobes that arrive while a request is outstanding launch nothing and do not step the counter.
- R6: `ref_count` counts the handshakes completed in the current sample period. It saturates at 31. On `sample_tick` it restarts at 0, or at 1 if a handshake completes in that same cycle.
- R7: `period_short` is a one-cycle pulse in the cycle after `sample_tick` when the period that just ended completed fewer than 8 handshakes. The first tick after reset never raises it.
- R8: A synchronous active-high `rst` clears the flag, the row counter, any outstanding request and the period monitor. During reset, `mem_req` is 0, `slave_ready` is 1, `ref_count` is 0 and `period_short` is 0.
- R9: `mem_ack` has no effect while no request is outstanding.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| refresh_on | input | 1 | Sets the refresh flag |
| refresh_off | input | 1 | Clears the refresh flag (has priority over `refresh_on`) |
| slave_ale | input | 1 | Slave address strobe, one per slave bus cycle |
| slave_addr | input | 16 | Slave address presented with the strobe |
| sample_tick | input | 1 | Start of a new sample period |
| mem_req | output | 1 | Shadow reference request (valid) |
| mem_ack | input | 1 | Memory grant (ready) |
| mem_addr | output | 16 | Shadow reference address: slave upper bits with the row counter in the low byte |
| slave_ready | output | 1 | Low to insert wait states into the slave's cycle |
| ref_count | output | 5 | Handshakes completed in the current period |
| period_short | output | 1 | Pulse indicating the previous period had too few references |

## Verification
An accepted strobe shows up as a raised `mem_req`, a new `mem_addr` and a low `slave_ready` one clock later. A grant shows up as a dropped request and a raised ready one clock after the cycle in which it is seen, with `ref_count` updating on that same edge. `period_short` appears one clock after the tick. The bench drives inputs just after each rising edge and advances a behavioural model on that same edge. At every falling edge it compares all outputs against the model, so each result is checked in exactly the cycle it is due. Directed checks sampled one step after an edge confirm the reset state, row wrap, counter saturation, ignored strobes and ignored grants.

// File: rtl/rdr_pkg.sv
package rdr_pkg;
  typedef enum logic {
    RQ_IDLE = 1'b0,
    RQ_WAIT = 1'b1
  } req_state_e;
endpackage

// File: rtl/rdr_enable_flag.sv
module rdr_enable_flag (
  input  logic clk,
  input  logic rst,
  input  logic set_i,
  input  logic clr_i,
  output logic en_o
);
  always_ff @(posedge clk) begin
    if (rst)        en_o <= 1'b0;
    else if (clr_i) en_o <= 1'b0;
    else if (set_i) en_o <= 1'b1;
  end
endmodule

// File: rtl/rdr_row_ctr.sv
module rdr_row_ctr #(
  parameter int ROW_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             step_i,
  output logic [ROW_W-1:0] row_o
);
  always_ff @(posedge clk) begin
    if (rst)         row_o <= '0;
    else if (step_i) row_o <= row_o + 1'b1;
  end
endmodule

// File: rtl/rdr_req_ctrl.sv
module rdr_req_ctrl
  import rdr_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int ROW_W  = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              ale_i,
  input  logic              en_i,
  input  logic [ADDR_W-1:0] slave_addr_i,
  input  logic [ROW_W-1:0]  row_i,
  input  logic              ack_i,
  output logic              take_o,
  output logic              done_o,
  output logic              req_o,
  output logic [ADDR_W-1:0] addr_o,
  output logic              ready_o
);
  req_state_e        state_q;
  logic [ADDR_W-1:0] next_addr;

  generate
    if (ADDR_W > ROW_W) begin : g_split
      assign next_addr = {slave_addr_i[ADDR_W-1:ROW_W], row_i};
    end else begin : g_row_only
      assign next_addr = row_i[ADDR_W-1:0];
    end
  endgenerate

  assign take_o  = ale_i && en_i && (state_q == RQ_IDLE);
  assign done_o  = (state_q == RQ_WAIT) && ack_i;
  assign req_o   = (state_q == RQ_WAIT);
  assign ready_o = (state_q == RQ_IDLE);

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= RQ_IDLE;
      addr_o  <= '0;
    end else if (take_o) begin
      state_q <= RQ_WAIT;
      addr_o  <= next_addr;
    end else if (done_o) begin
      state_q <= RQ_IDLE;
    end
  end
endmodule

// File: rtl/rdr_period_mon.sv
module rdr_period_mon #(
  parameter int CNT_W    = 5,
  parameter int MIN_REFS = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             tick_i,
  input  logic             done_i,
  output logic [CNT_W-1:0] count_o,
  output logic             short_o
);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;
  localparam logic [CNT_W-1:0] CNT_MIN = CNT_W'(MIN_REFS);

  logic armed_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      count_o <= '0;
      short_o <= 1'b0;
      armed_q <= 1'b0;
    end else if (tick_i) begin
      short_o <= armed_q && (count_o < CNT_MIN);
      armed_q <= 1'b1;
      count_o <= done_i ? CNT_W'(1) : '0;
    end else begin
      short_o <= 1'b0;
      if (done_i && (count_o != CNT_MAX)) count_o <= count_o + 1'b1;
    end
  end
endmodule

// File: rtl/rdr_refresh_seq.sv
module rdr_refresh_seq #(
  parameter int ADDR_W   = 16,
  parameter int ROW_W    = 8,
  parameter int CNT_W    = 5,
  parameter int MIN_REFS = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              refresh_on,
  input  logic              refresh_off,
  input  logic              slave_ale,
  input  logic [ADDR_W-1:0] slave_addr,
  input  logic              sample_tick,
  output logic              mem_req,
  input  logic              mem_ack,
  output logic [ADDR_W-1:0] mem_addr,
  output logic              slave_ready,
  output logic [CNT_W-1:0]  ref_count,
  output logic              period_short
);
  logic             en_q;
  logic [ROW_W-1:0] row_q;
  logic             take;
  logic             done;

  rdr_enable_flag u_flag (
    .clk(clk), .rst(rst), .set_i(refresh_on), .clr_i(refresh_off), .en_o(en_q)
  );

  rdr_row_ctr #(.ROW_W(ROW_W)) u_row (
    .clk(clk), .rst(rst), .step_i(take), .row_o(row_q)
  );

  rdr_req_ctrl #(.ADDR_W(ADDR_W), .ROW_W(ROW_W)) u_req (
    .clk(clk), .rst(rst), .ale_i(slave_ale), .en_i(en_q),
    .slave_addr_i(slave_addr), .row_i(row_q), .ack_i(mem_ack),
    .take_o(take), .done_o(done), .req_o(mem_req), .addr_o(mem_addr),
    .ready_o(slave_ready)
  );

  rdr_period_mon #(.CNT_W(CNT_W), .MIN_REFS(MIN_REFS)) u_mon (
    .clk(clk), .rst(rst), .tick_i(sample_tick), .done_i(done),
    .count_o(ref_count), .short_o(period_short)
  );
endmodule

// File: rtl/rdr_refresh_seq_chk.sv
module rdr_refresh_seq_chk #(
  parameter int ADDR_W = 16,
  parameter int ROW_W  = 8
) (
  input logic              clk,
  input logic              rst,
  input logic              slave_ale,
  input logic              sample_tick,
  input logic              mem_req,
  input logic              mem_ack,
  input logic [ADDR_W-1:0] mem_addr,
  input logic              period_short,
  input logic              en_i,
  input logic [ROW_W-1:0]  row_i
);
  p_flag_gate_r1: assert property (@(posedge clk) disable iff (rst)
    $rose(mem_req) |-> ($past(en_i) && $past(slave_ale)));

  p_row_step_r2: assert property (@(posedge clk) disable iff (rst)
    (slave_ale && en_i && !mem_req) |=> (row_i == ROW_W'($past(row_i) + 1'b1)));

  p_row_hold_r2: assert property (@(posedge clk) disable iff (rst)
    !en_i |=> $stable(row_i));

  p_req_hold_r4: assert property (@(posedge clk) disable iff (rst)
    (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr)));

  p_req_drop_r4: assert property (@(posedge clk) disable iff (rst)
    (mem_req && mem_ack) |=> !mem_req);

  p_stall_r5: assert property (@(posedge clk) disable iff (rst)
    (slave_ale && mem_req) |=> $stable(row_i));

  p_short_r7: assert property (@(posedge clk) disable iff (rst)
    period_short |-> $past(sample_tick));
endmodule

bind rdr_refresh_seq rdr_refresh_seq_chk #(.ADDR_W(ADDR_W), .ROW_W(ROW_W)) u_chk (
  .clk(clk), .rst(rst), .slave_ale(slave_ale), .sample_tick(sample_tick),
  .mem_req(mem_req), .mem_ack(mem_ack), .mem_addr(mem_addr),
  .period_short(period_short), .en_i(en_q), .row_i(row_q)
);

// File: tb/tb_rdr_refresh_seq.sv
`timescale 1ns/1ps
module tb_rdr_refresh_seq;
  localparam int ADDR_W = 16;
  localparam int CNT_W  = 5;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic              rst = 1'b1;
  logic              refresh_on = 1'b0, refresh_off = 1'b0;
  logic              slave_ale = 1'b0;
  logic [ADDR_W-1:0] slave_addr = '0;
  logic              sample_tick = 1'b0;
  logic              mem_ack = 1'b0;
  logic              mem_req, slave_ready, period_short;
  logic [ADDR_W-1:0] mem_addr;
  logic [CNT_W-1:0]  ref_count;

  rdr_refresh_seq dut (
    .clk(clk), .rst(rst), .refresh_on(refresh_on), .refresh_off(refresh_off),
    .slave_ale(slave_ale), .slave_addr(slave_addr), .sample_tick(sample_tick),
    .mem_req(mem_req), .mem_ack(mem_ack), .mem_addr(mem_addr),
    .slave_ready(slave_ready), .ref_count(ref_count), .period_short(period_short)
  );

  int checks = 0, errors = 0, cycles = 0;
  bit cmp_on = 0;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual %0h expected %0h", req, act, exp);
    end
  endtask

  // Behavioural reference model
  bit m_en, m_pend, m_armed, m_short;
  int m_row, m_addr, m_cnt;
  always @(posedge clk) begin
    bit done;
    done = m_pend && mem_ack;
    if (rst) begin
      m_en = 0; m_pend = 0; m_armed = 0; m_short = 0;
      m_row = 0; m_addr = 0; m_cnt = 0;
    end else begin
      if (slave_ale && m_en && !m_pend) begin
        m_addr = (int'(slave_addr) & 'hFF00) | m_row;
        m_row  = (m_row + 1) % 256;
        m_pend = 1;
      end else if (done) m_pend = 0;
      if (sample_tick) begin
        m_short = m_armed && (m_cnt < 8);
        m_armed = 1;
        m_cnt   = done ? 1 : 0;
      end else begin
        m_short = 0;
        if (done && m_cnt < 31) m_cnt++;
      end
      if (refresh_off) m_en = 0;
      else if (refresh_on) m_en = 1;
    end
  end

  always @(negedge clk) begin
    if (cmp_on) begin
      chk(mem_req === m_pend, "R4 mem_req", int'(mem_req), int'(m_pend));
      chk(mem_addr[7:0] === 8'(m_addr), "R2 row", int'(mem_addr[7:0]), m_addr & 'hFF);
      chk(mem_addr[15:8] === 8'(m_addr >> 8), "R3 upper", int'(mem_addr[15:8]), m_addr >> 8);
      chk(slave_ready === !m_pend, "R5 ready", int'(slave_ready), int'(!m_pend));
      chk(ref_count === 5'(m_cnt), "R6 count", int'(ref_count), m_cnt);
      chk(period_short === m_short, "R7 short", int'(period_short), int'(m_short));
    end
  end

  // Grant responder
  int ack_lat = 0, wcnt = 0;
  bit force_ack = 0;
  always @(posedge clk) begin
    #2;
    if (mem_req && !mem_ack) begin
      if (wcnt >= ack_lat) mem_ack = 1'b1;
      else wcnt++;
    end else begin
      mem_ack = force_ack;
      wcnt = 0;
    end
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 200000) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  task automatic step();
    @(posedge clk); #1;
  endtask

  task automatic strobe(input logic [15:0] a);
    slave_ale = 1'b1; slave_addr = a;
    step();
    slave_ale = 1'b0;
    while (mem_req) step();
  endtask

  task automatic pulse_on(); refresh_on = 1'b1; step(); refresh_on = 1'b0; endtask
  task automatic pulse_off(); refresh_off = 1'b1; step(); refresh_off = 1'b0; endtask
  task automatic tick(); sample_tick = 1'b1; step(); sample_tick = 1'b0; endtask

  initial begin
    repeat (3) step();
    // R8 reset state
    chk(mem_req === 1'b0, "R8 req", int'(mem_req), 0);
    chk(slave_ready === 1'b1, "R8 ready", int'(slave_ready), 1);
    chk(ref_count === '0, "R8 count", int'(ref_count), 0);
    chk(period_short === 1'b0, "R8 short", int'(period_short), 0);
    cmp_on = 1;
    rst = 1'b0;
    step();

    // R1: strobe with flag clear launches nothing; first tick never short (R7)
    strobe(16'h1200);
    chk(ref_count === '0, "R1 off", int'(ref_count), 0);
    tick();
    chk(period_short === 1'b0, "R7 first tick", int'(period_short), 0);

    // full period of 8 references
    pulse_on();
    for (int i = 0; i < 8; i++) begin
      ack_lat = i % 4;
      strobe(16'hA500 + 16'(i * 'h300));
    end
    chk(ref_count === 5'd8, "R6 eight", int'(ref_count), 8);
    tick();
    chk(period_short === 1'b0, "R7 full period", int'(period_short), 0);

    // short period
    ack_lat = 2;
    for (int i = 0; i < 3; i++) strobe(16'h3C00);
    tick();
    chk(period_short === 1'b1, "R7 short period", int'(period_short), 1);

    // R1: cleared flag, then set+clear together
    pulse_off();
    strobe(16'h7700);
    chk(ref_count === 5'd0, "R1 cleared", int'(ref_count), 0);
    refresh_on = 1'b1; refresh_off = 1'b1; step();
    refresh_on = 1'b0; refresh_off = 1'b0;
    strobe(16'h7800);
    chk(ref_count === 5'd0, "R1 clear wins", int'(ref_count), 0);

    // wrap and saturation
    pulse_on();
    ack_lat = 1;
    for (int i = 0; i < 260; i++) strobe(16'(i << 8));
    chk(mem_addr[7:0] === 8'd14, "R2 wrap", int'(mem_addr[7:0]), 14);
    chk(ref_count === 5'd31, "R6 saturate", int'(ref_count), 31);

    // R5: strobe held while outstanding
    tick();
    ack_lat = 4;
    slave_ale = 1'b1; slave_addr = 16'hBE00;
    repeat (3) step();
    slave_ale = 1'b0;
    while (mem_req) step();
    chk(ref_count === 5'd1, "R5 stall", int'(ref_count), 1);
    chk(mem_addr[7:0] === 8'd15, "R5 row", int'(mem_addr[7:0]), 15);

    // R9: grant with no request
    force_ack = 1; repeat (3) step(); force_ack = 0; step();
    chk(ref_count === 5'd1, "R9 count", int'(ref_count), 1);
    chk(mem_req === 1'b0, "R9 req", int'(mem_req), 0);

    tick();
    chk(period_short === 1'b1, "R7 one ref", int'(period_short), 1);
    step();

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule